// File: doc/BRIEF.md
# Guest Supervisor Status Register

This block holds the status word a guest operating system sees as its supervisor status, on a core that can host virtual machines. Hypervisor or machine software reaches it at its own CSR address. While the core runs a guest (virtualization mode V=1), the guest's accesses to the ordinary supervisor-status address are served by this register. A guest that names the register's own address gets a virtual-instruction fault and changes nothing.

The register keeps the guest's interrupt enable and its saved copy, the previous privilege, the memory-access controls, the three extension-state fields and, in the 64-bit layout, the user XLEN selector. A summary-dirty bit is derived from the extension-state fields. Trap-entry and SRET strobes update the interrupt and privilege fields. Reads are combinational in the cycle of the access. Writes, traps and returns take effect at the next clock edge.

Top module: `guest_status_reg`

## Requirements
- R1: After reset every field reads 0, except the user XLEN selector, which reads 2 (64-bit) in the 64-bit layout. A read at the register's own address then returns 0x0000_0002_0000_0000.
- R2: An access with V=0, privilege not user (privilege code 0 = user, 1 = supervisor, 3 = machine) and address 0x200 is served. It reads the image and, with write enable set, writes it. Bit positions: interrupt enable 1, saved enable 5, user big-endian 6, previous privilege 8, vector state 10:9, float state 14:13, extension state 16:15, user-page access 18, make-executable-readable 19, user XLEN 33:32 (64-bit layout only).
- R3: With V=1 and guest privilege supervisor, an access to the supervisor-status address 0x100 is served by this register. With V=0, address 0x100 is not served: the hit flag is 0 and the read data is 0.
- R4: An access to 0x200 with V=1 raises the fault flag, returns 0, and leaves every field unchanged, even when write enable is set.
- R5: Every bit not named in R2 or R6 reads 0, whatever value was written to it.
- R6: The summary-dirty bit (bit 63 in the 64-bit layout, bit 31 in the 32-bit layout) reads 1 exactly when at least one of the float, vector or extension state fields equals 3 (Dirty). Encoding: 0 Off, 1 Initial, 2 Clean, 3 Dirty. A write to this bit has no effect.
- R7: The user XLEN field accepts only 1 (32-bit) or 2 (64-bit). A write of 0 or 3 leaves its previous legal value in place.
- R8: On trap entry the saved enable takes the old interrupt enable, the interrupt enable clears, and the previous privilege becomes 1 if the trapped code ran at supervisor and 0 if it ran at user.
- R9: On SRET the interrupt enable takes the saved enable, the saved enable becomes 1, and the previous privilege becomes 0. The previous-privilege output read before the return selects the return mode: 1 = guest supervisor, 0 = guest user.
- R10: When events coincide, trap entry wins over SRET and SRET wins over a CSR write. The losing update is dropped completely.
- R11: An access at privilege user to 0x200 (any V), or to 0x100 with V=1, raises the fault flag and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csrEn | input | 1 | A CSR access is presented this cycle |
| csrWe | input | 1 | The access also writes |
| csrAddr | input | 12 | CSR address |
| csrWdata | input | XLEN | Write data |
| csrRdata | output | XLEN | Read image, 0 when the access is not served |
| accHit | output | 1 | The access is served by this register |
| accFault | output | 1 | The access faults (virtual-instruction or illegal) |
| virtMode | input | 1 | Current virtualization mode V |
| privLevel | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| trapEnter | input | 1 | A trap into guest supervisor is taken at this edge |
| sretExec | input | 1 | A guest SRET retires at this edge |
| sieOut | output | 1 | Interrupt enable |
| spieOut | output | 1 | Saved interrupt enable |
| sppOut | output | 1 | Previous privilege / return mode |
| ubeOut | output | 1 | User explicit accesses big-endian |
| sumOut | output | 1 | Supervisor may touch user pages |
| mxrOut | output | 1 | Executable pages readable by loads |
| fsOut | output | 2 | Float state |
| vsOut | output | 2 | Vector state |
| xsOut | output | 2 | Extension state |
| uxlOut | output | 2 | User XLEN selector (0 in 32-bit layout) |

## Verification
The assertions assume that trap entry and SRET strobes come from retiring instructions and last one cycle. They also assume that privilege and virtualization mode are stable for the cycle of an access. The bench holds every strobe for exactly one cycle and changes mode and privilege only between accesses. It drives coincident trap, SRET and write only in the priority test. There it pulses them together once, so the properties that exclude a trap in the same cycle are still exercised on their own elsewhere.

// File: rtl/gsr_pkg.sv
package gsr_pkg;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;

  localparam logic [1:0] EXT_DIRTY = 2'd3;
  localparam logic [1:0] UXL_32 = 2'd1;
  localparam logic [1:0] UXL_64 = 2'd2;

  // bit positions that software decodes
  localparam int POS_SIE  = 1;
  localparam int POS_SPIE = 5;
  localparam int POS_UBE  = 6;
  localparam int POS_SPP  = 8;
  localparam int POS_VS   = 9;
  localparam int POS_FS   = 13;
  localparam int POS_XS   = 15;
  localparam int POS_SUM  = 18;
  localparam int POS_MXR  = 19;
  localparam int POS_UXL  = 32;

  typedef struct packed {
    logic       sie;
    logic       spie;
    logic       ube;
    logic       spp;
    logic [1:0] vs;
    logic [1:0] fs;
    logic [1:0] xs;
    logic       sum;
    logic       mxr;
    logic [1:0] uxl;
  } gsrFields_t;

  typedef struct packed {
    logic wrEn;
    logic trapEn;
    logic sretEn;
    logic fromSuper;
  } gsrStrobe_t;

endpackage

// File: rtl/gsr_ctl.sv
module gsr_ctl
  import gsr_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter logic [11:0] OWN_ADDR   = 12'h200,
  parameter logic [11:0] ALIAS_ADDR = 12'h100
) (
  input  logic              csrEn,
  input  logic              csrWe,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic              virtMode,
  input  logic [1:0]        privLevel,
  input  logic              trapEnter,
  input  logic              sretExec,
  output gsrStrobe_t        strb,
  output logic              accHit,
  output logic              accFault
);

  logic selOwn, selAlias, isUser;

  always_comb begin
    selOwn   = csrEn && (csrAddr == OWN_ADDR[ADDR_W-1:0]);
    selAlias = csrEn && (csrAddr == ALIAS_ADDR[ADDR_W-1:0]);
    isUser   = (privLevel == PRIV_U);

    // own address: only hypervisor/machine software outside a guest
    // alias address: only while a guest runs, at guest supervisor
    accHit   = (selOwn && !virtMode && !isUser) ||
               (selAlias && virtMode && !isUser);
    accFault = (selOwn && (virtMode || isUser)) ||
               (selAlias && virtMode && isUser);

    strb.trapEn    = trapEnter;
    strb.sretEn    = sretExec && !trapEnter;
    strb.wrEn      = accHit && csrWe && !trapEnter && !sretExec;
    strb.fromSuper = (privLevel == PRIV_S);
  end

endmodule

// File: rtl/gsr_dp.sv
module gsr_dp
  import gsr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  gsrStrobe_t      strb,
  input  logic [XLEN-1:0] wdata,
  output gsrFields_t      cur,
  output logic [XLEN-1:0] rdImg
);

  localparam bit         HAS_UXL   = (XLEN == 64);
  localparam logic [1:0] UXL_RESET = HAS_UXL ? UXL_64 : 2'd0;

  gsrFields_t nxt;
  logic       anyDirty;
  logic [1:0] uxlWr;
  logic       uxlLegal;
  logic [31:0] lowImg;

  generate
    if (HAS_UXL) begin : g_uxl
      assign uxlWr = wdata[POS_UXL+1:POS_UXL];
    end else begin : g_nouxl
      assign uxlWr = 2'd0;
    end
  endgenerate

  always_comb begin
    uxlLegal = HAS_UXL && ((uxlWr == UXL_32) || (uxlWr == UXL_64));
    nxt = cur;
    if (strb.trapEn) begin
      nxt.spie = cur.sie;
      nxt.sie  = 1'b0;
      nxt.spp  = strb.fromSuper;
    end else if (strb.sretEn) begin
      nxt.sie  = cur.spie;
      nxt.spie = 1'b1;
      nxt.spp  = 1'b0;
    end else if (strb.wrEn) begin
      nxt.sie  = wdata[POS_SIE];
      nxt.spie = wdata[POS_SPIE];
      nxt.ube  = wdata[POS_UBE];
      nxt.spp  = wdata[POS_SPP];
      nxt.vs   = wdata[POS_VS+1:POS_VS];
      nxt.fs   = wdata[POS_FS+1:POS_FS];
      nxt.xs   = wdata[POS_XS+1:POS_XS];
      nxt.sum  = wdata[POS_SUM];
      nxt.mxr  = wdata[POS_MXR];
      if (uxlLegal) nxt.uxl = uxlWr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur     <= '0;
      cur.uxl <= UXL_RESET;
    end else begin
      cur <= nxt;
    end
  end

  always_comb begin
    anyDirty = (cur.fs == EXT_DIRTY) || (cur.vs == EXT_DIRTY) ||
               (cur.xs == EXT_DIRTY);
    lowImg = '0;
    lowImg[POS_SIE]            = cur.sie;
    lowImg[POS_SPIE]           = cur.spie;
    lowImg[POS_UBE]            = cur.ube;
    lowImg[POS_SPP]            = cur.spp;
    lowImg[POS_VS+1:POS_VS]    = cur.vs;
    lowImg[POS_FS+1:POS_FS]    = cur.fs;
    lowImg[POS_XS+1:POS_XS]    = cur.xs;
    lowImg[POS_SUM]            = cur.sum;
    lowImg[POS_MXR]            = cur.mxr;
  end

  generate
    if (HAS_UXL) begin : g_img64
      always_comb begin
        rdImg = '0;
        rdImg[31:0]              = lowImg;
        rdImg[POS_UXL+1:POS_UXL] = cur.uxl;
        rdImg[XLEN-1]            = anyDirty;
      end
    end else begin : g_img32
      always_comb begin
        rdImg = lowImg[XLEN-1:0];
        rdImg[XLEN-1] = anyDirty;
      end
    end
  endgenerate

endmodule

// File: rtl/guest_status_reg.sv
module guest_status_reg
  import gsr_pkg::*;
#(
  parameter int          XLEN       = 64,
  parameter int          ADDR_W     = 12,
  parameter logic [11:0] OWN_ADDR   = 12'h200,
  parameter logic [11:0] ALIAS_ADDR = 12'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csrEn,
  input  logic              csrWe,
  input  logic [ADDR_W-1:0] csrAddr,
  input  logic [XLEN-1:0]   csrWdata,
  output logic [XLEN-1:0]   csrRdata,
  output logic              accHit,
  output logic              accFault,
  input  logic              virtMode,
  input  logic [1:0]        privLevel,
  input  logic              trapEnter,
  input  logic              sretExec,
  output logic              sieOut,
  output logic              spieOut,
  output logic              sppOut,
  output logic              ubeOut,
  output logic              sumOut,
  output logic              mxrOut,
  output logic [1:0]        fsOut,
  output logic [1:0]        vsOut,
  output logic [1:0]        xsOut,
  output logic [1:0]        uxlOut
);

  gsrStrobe_t      strb;
  gsrFields_t      cur;
  logic [XLEN-1:0] rdImg;

  gsr_ctl #(
    .ADDR_W(ADDR_W), .OWN_ADDR(OWN_ADDR), .ALIAS_ADDR(ALIAS_ADDR)
  ) ctl_i (
    .csrEn(csrEn), .csrWe(csrWe), .csrAddr(csrAddr),
    .virtMode(virtMode), .privLevel(privLevel),
    .trapEnter(trapEnter), .sretExec(sretExec),
    .strb(strb), .accHit(accHit), .accFault(accFault)
  );

  gsr_dp #(.XLEN(XLEN)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wdata(csrWdata),
    .cur(cur), .rdImg(rdImg)
  );

  assign csrRdata = accHit ? rdImg : '0;
  assign sieOut   = cur.sie;
  assign spieOut  = cur.spie;
  assign sppOut   = cur.spp;
  assign ubeOut   = cur.ube;
  assign sumOut   = cur.sum;
  assign mxrOut   = cur.mxr;
  assign fsOut    = cur.fs;
  assign vsOut    = cur.vs;
  assign xsOut    = cur.xs;
  assign uxlOut   = cur.uxl;

endmodule

// File: rtl/gsr_chk.sv
module gsr_chk #(
  parameter int          XLEN       = 64,
  parameter int          ADDR_W     = 12,
  parameter logic [11:0] ALIAS_ADDR = 12'h100
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] csrAddr,
  input logic [XLEN-1:0]   csrRdata,
  input logic              accHit,
  input logic              accFault,
  input logic              virtMode,
  input logic              trapEnter,
  input logic              sretExec,
  input logic              sieOut,
  input logic              spieOut,
  input logic              sppOut,
  input logic              ubeOut,
  input logic              sumOut,
  input logic              mxrOut,
  input logic [1:0]        fsOut,
  input logic [1:0]        vsOut,
  input logic [1:0]        xsOut,
  input logic [1:0]        uxlOut
);

  logic [13:0] fieldVec;
  assign fieldVec = {sieOut, spieOut, sppOut, ubeOut, sumOut, mxrOut,
                     fsOut, vsOut, xsOut, uxlOut};

  a_r3_alias_needs_guest: assert property (@(posedge clk) disable iff (!rst_n)
    (accHit && csrAddr == ALIAS_ADDR[ADDR_W-1:0]) |-> virtMode);

  a_r4_fault_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    accFault |-> (csrRdata == '0 && !accHit));

  a_r4_fault_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
    (accFault && !trapEnter && !sretExec) |=> $stable(fieldVec));

  a_r6_sd_summary: assert property (@(posedge clk) disable iff (!rst_n)
    accHit |-> (csrRdata[XLEN-1] ==
                (fsOut == 2'd3 || vsOut == 2'd3 || xsOut == 2'd3)));

  a_r8_trap_saves_enable: assert property (@(posedge clk) disable iff (!rst_n)
    trapEnter |=> (!sieOut && spieOut == $past(sieOut)));

  a_r9_sret_restores: assert property (@(posedge clk) disable iff (!rst_n)
    (sretExec && !trapEnter) |=> (!sppOut && spieOut && sieOut == $past(spieOut)));

  generate
    if (XLEN == 64) begin : g_uxl_chk
      a_r7_uxl_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (uxlOut == 2'd1 || uxlOut == 2'd2));
    end
  endgenerate

endmodule

bind guest_status_reg gsr_chk #(
  .XLEN(XLEN), .ADDR_W(ADDR_W), .ALIAS_ADDR(ALIAS_ADDR)
) chk_i (
  .clk(clk), .rst_n(rst_n), .csrAddr(csrAddr), .csrRdata(csrRdata),
  .accHit(accHit), .accFault(accFault), .virtMode(virtMode),
  .trapEnter(trapEnter), .sretExec(sretExec),
  .sieOut(sieOut), .spieOut(spieOut), .sppOut(sppOut), .ubeOut(ubeOut),
  .sumOut(sumOut), .mxrOut(mxrOut), .fsOut(fsOut), .vsOut(vsOut),
  .xsOut(xsOut), .uxlOut(uxlOut)
);

// File: tb/guest_status_reg_tb_top.sv
module guest_status_reg_tb_top;

  localparam int XLEN = 64;
  localparam logic [11:0] OWN = 12'h200;
  localparam logic [11:0] ALI = 12'h100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csrEn = 1'b0, csrWe = 1'b0;
  logic [11:0] csrAddr = '0;
  logic [XLEN-1:0] csrWdata = '0;
  logic [XLEN-1:0] csrRdata;
  logic accHit, accFault;
  logic virtMode = 1'b0;
  logic [1:0] privLevel = 2'd1;
  logic trapEnter = 1'b0, sretExec = 1'b0;
  logic sieOut, spieOut, sppOut, ubeOut, sumOut, mxrOut;
  logic [1:0] fsOut, vsOut, xsOut, uxlOut;

  always #5 clk = ~clk;

  guest_status_reg #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .csrEn(csrEn), .csrWe(csrWe),
    .csrAddr(csrAddr), .csrWdata(csrWdata), .csrRdata(csrRdata),
    .accHit(accHit), .accFault(accFault), .virtMode(virtMode),
    .privLevel(privLevel), .trapEnter(trapEnter), .sretExec(sretExec),
    .sieOut(sieOut), .spieOut(spieOut), .sppOut(sppOut), .ubeOut(ubeOut),
    .sumOut(sumOut), .mxrOut(mxrOut), .fsOut(fsOut), .vsOut(vsOut),
    .xsOut(xsOut), .uxlOut(uxlOut)
  );

  // scoreboard item: kind 0 rdata, 1 fault, 2 hit, 3 field pins
  typedef struct {
    string tag;
    int kind;
    logic [63:0] exp;
  } scItem_t;

  scItem_t sb[$];
  int nCmp = 0, nBad = 0;

  // bench model of the fields, from the requirements
  logic mSie = 0, mSpie = 0, mUbe = 0, mSpp = 0, mSum = 0, mMxr = 0;
  logic [1:0] mVs = 0, mFs = 0, mXs = 0, mUxl = 2'd2;

  function automatic logic [63:0] modelImg();
    logic [63:0] v = '0;
    v[1] = mSie; v[5] = mSpie; v[6] = mUbe; v[8] = mSpp;
    v[10:9] = mVs; v[14:13] = mFs; v[16:15] = mXs;
    v[18] = mSum; v[19] = mMxr; v[33:32] = mUxl;
    v[63] = (mFs == 3) || (mVs == 3) || (mXs == 3);
    return v;
  endfunction

  function automatic logic [63:0] modelPins();
    return {50'd0, mSie, mSpie, mSpp, mUbe, mSum, mMxr, mFs, mVs, mXs, mUxl};
  endfunction

  task automatic push(input string tag, input int kind, input logic [63:0] e);
    scItem_t it;
    it.tag = tag; it.kind = kind; it.exp = e;
    sb.push_back(it);
  endtask

  // one cycle of stimulus; expectations refer to this cycle, model updates at the edge
  task automatic op(input string tag, input logic en, input logic we,
                    input logic [11:0] a, input logic [63:0] wd,
                    input logic v, input logic [1:0] p,
                    input logic tr, input logic sr, input logic pins);
    logic served, fault;
    csrEn = en; csrWe = we; csrAddr = a; csrWdata = wd;
    virtMode = v; privLevel = p; trapEnter = tr; sretExec = sr;
    served = en && ((a == OWN && !v && p != 0) || (a == ALI && v && p != 0));
    fault  = en && ((a == OWN && (v || p == 0)) || (a == ALI && v && p == 0));
    if (en) begin
      push(tag, 0, served ? modelImg() : 64'd0);
      push(tag, 1, {63'd0, fault});
      push(tag, 2, {63'd0, served});
    end
    if (pins) push(tag, 3, modelPins());
    @(posedge clk);
    if (tr) begin
      mSpie = mSie; mSie = 0; mSpp = (p == 2'd1);
    end else if (sr) begin
      mSie = mSpie; mSpie = 1; mSpp = 0;
    end else if (served && we) begin
      mSie = wd[1]; mSpie = wd[5]; mUbe = wd[6]; mSpp = wd[8];
      mVs = wd[10:9]; mFs = wd[14:13]; mXs = wd[16:15];
      mSum = wd[18]; mMxr = wd[19];
      if (wd[33:32] == 2'd1 || wd[33:32] == 2'd2) mUxl = wd[33:32];
    end
    #1;
    csrEn = 0; csrWe = 0; trapEnter = 0; sretExec = 0;
  endtask

  task automatic rdOwn(input string tag);
    op(tag, 1, 0, OWN, '0, 0, 2'd1, 0, 0, 1);
  endtask

  task automatic wrOwn(input string tag, input logic [63:0] wd);
    op(tag, 1, 1, OWN, wd, 0, 2'd1, 0, 0, 0);
  endtask

  // monitor
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      scItem_t it;
      logic [63:0] act;
      it = sb.pop_front();
      case (it.kind)
        0: act = csrRdata;
        1: act = {63'd0, accFault};
        2: act = {63'd0, accHit};
        default: act = {50'd0, sieOut, spieOut, sppOut, ubeOut, sumOut,
                        mxrOut, fsOut, vsOut, xsOut, uxlOut};
      endcase
      nCmp++;
      if (act !== it.exp) begin
        nBad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset image
    rdOwn("R1 reset image");
    // R2 R5 R6 R7 all-ones write: WPRI zero, UXL keeps 2, SD set
    wrOwn("R2 write ones", '1);
    rdOwn("R2 R5 R7 readback after ones");
    // R7 legal 1, then reserved 0 and 3 rejected
    wrOwn("R7 set uxl 1", 64'h1_0000_0000);
    rdOwn("R7 uxl 1 stored");
    wrOwn("R7 reserved 0", 64'h0);
    rdOwn("R7 reserved 0 rejected");
    wrOwn("R7 reserved 3", 64'h3_0000_0000);
    rdOwn("R7 reserved 3 rejected");
    wrOwn("R7 back to 2", 64'h2_0000_0000);
    // R6 summary dirty over every combination
    for (int c = 0; c < 64; c++) begin
      logic [63:0] wd;
      wd = 64'h2_0000_0000;
      wd[14:13] = c[1:0]; wd[10:9] = c[3:2]; wd[16:15] = c[5:4];
      wd[63] = ~wd[63];
      wrOwn("R6 sd combo write", wd);
      rdOwn("R6 sd combo read");
    end
    // R3 alias while guest supervisor
    op("R3 alias write", 1, 1, ALI, 64'h2_000C_0042, 1, 2'd1, 0, 0, 0);
    op("R3 alias read", 1, 0, ALI, '0, 1, 2'd1, 0, 0, 1);
    rdOwn("R3 alias visible at own address");
    op("R3 supervisor address not served when V=0", 1, 1, ALI, '1, 0, 2'd1, 0, 0, 0);
    rdOwn("R3 unchanged after V=0 access");
    // R4 guest touching own address
    op("R4 guest direct write faults", 1, 1, OWN, '0, 1, 2'd1, 0, 0, 0);
    rdOwn("R4 state unchanged");
    // R11 user access faults
    op("R11 user own address", 1, 1, OWN, '0, 0, 2'd0, 0, 0, 0);
    op("R11 guest user alias", 1, 1, ALI, '0, 1, 2'd0, 0, 0, 1);
    // R8 R9 trap from supervisor then return
    wrOwn("R8 set sie", 64'h2_0000_0002);
    op("R8 trap from S", 0, 0, OWN, '0, 1, 2'd1, 1, 0, 0);
    rdOwn("R8 after trap from S");
    op("R9 sret to S", 0, 0, OWN, '0, 1, 2'd1, 0, 1, 0);
    rdOwn("R9 after sret");
    // R8 R9 trap from user with sie 0
    wrOwn("R8 clear sie", 64'h2_0000_0000);
    op("R8 trap from U", 0, 0, OWN, '0, 1, 2'd0, 1, 0, 0);
    rdOwn("R8 after trap from U");
    op("R9 sret to U", 0, 0, OWN, '0, 1, 2'd1, 0, 1, 0);
    rdOwn("R9 after sret to U");
    // R10 priorities
    wrOwn("R10 prep", 64'h2_0000_0022);
    op("R10 trap+sret+write", 1, 1, OWN, 64'h2_000C_0000, 0, 2'd1, 1, 1, 0);
    rdOwn("R10 trap won");
    op("R10 sret+write", 1, 1, OWN, 64'h2_000C_0000, 0, 2'd1, 0, 1, 0);
    rdOwn("R10 sret won");
    @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule